// File: doc/BRIEF.md
# Indexed Audio Codec Control Register Interface

This block is the host-facing control port of an audio codec. A byte-wide bus reaches four direct locations: an index pointer, a data window onto the register selected by that pointer, an interrupt status byte, and a programmed-I/O data byte. Behind the data window sit 32 indirect 8-bit control registers. Only the lower 16 are visible until a wide-addressing mode bit is set.

The block enforces the write rules of the control file. Some locations are read-only or reserved, and some bits are fixed. Writes to the playback format register are gated by two different mode-change enables: one opens the whole byte, the other opens only the upper nibble. An auto-calibration busy flag is armed when the index-pointer enable rises and drains by one on each read of the status/init register. One interrupt source is acknowledged in two ways. The raw register file, an interrupt line and a one-cycle pulse for every accepted format write are brought out for the rest of the codec.

Top module: `codec_regif`

## Requirements
- R1: Direct port 0 holds a 7-bit index pointer. It resets to 0x40 and reads back with bit 7 always 0; bit 6 is the mode-change enable (MCE). Port 3 always reads 0x00, and writes to it change nothing.
- R2: While bit 6 of indirect register 12 (wide mode) is clear, the indirect register is selected by index bits 3:0 only. While it is set, bits 4:0 select it.
- R3: After reset the indirect registers read 0x88 (2, 3, 4, 5, 18, 19), 0x80 (6, 7), 0x08 (9), 0x8A (12), 0xA0 (25, 26) and 0x00 (all others).
- R4: Writes to registers 21, 27 and 29 and to register 11 are discarded. In register 12 only bit 6 takes the written value. Bit 5 of register 9 is always stored as 0.
- R5: A write to register 8 while MCE is set stores the whole byte.
- R6: A write to register 8 while MCE is clear and bit 4 of register 24 is set stores bits 7:4 of the new value and keeps bits 3:0.
- R7: A write to register 8 with neither enable set is dropped. `fmt_load` is high for exactly the one cycle after each accepted register 8 write and is low otherwise.
- R8: When an index write takes MCE from 0 to 1 while bits 4:3 of register 9 are not both 0, a busy counter loads CAL_RELOAD. Each read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R9: Any write to port 2 clears the status INT bit (port 2 bit 0) and bits 6:4 of register 24, and drops `irq`.
- R10: A register 24 write that takes bit 4 from 1 to 0 clears INT and drops `irq`. Setting bit 4 by a write does not raise INT.
- R11: A `set_irq` pulse sets INT and bit 4 of register 24 and raises `irq`. When it falls in the same cycle as an R9 or R10 clear, the set wins.
- R12: Port 2 reads {7'b0, INT}, and `irq` always equals INT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Direct port select (0 index, 1 data, 2 status, 3 PIO) |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| set_irq | input | 1 | Playback interrupt event |
| irq | output | 1 | Interrupt line, equal to status INT |
| fmt_load | output | 1 | One-cycle pulse after an accepted format write |
| regs_flat | output | 256 | Raw indirect registers, register n at bits 8n+7:8n |

## Verification
An interrupt event can land in the same cycle as either acknowledge path: a status-port write or a register 24 write that clears bit 4. The bench provokes both collisions on purpose, and random traffic also pulses `set_irq` alongside writes of every kind. Each collision is judged by reading port 2 and register 24 afterwards. INT, `irq` and register 24 bit 4 must all be 1, while bits 6:5 of register 24 are still cleared by the status write.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SEL_W   = 5;

  localparam logic [SEL_W-1:0] IX_FMT    = 5'd8;
  localparam logic [SEL_W-1:0] IX_IFCFG  = 5'd9;
  localparam logic [SEL_W-1:0] IX_INIT   = 5'd11;
  localparam logic [SEL_W-1:0] IX_MODE   = 5'd12;
  localparam logic [SEL_W-1:0] IX_ALTST  = 5'd24;
  localparam logic [SEL_W-1:0] IX_RSV_A  = 5'd21;
  localparam logic [SEL_W-1:0] IX_RSV_B  = 5'd27;
  localparam logic [SEL_W-1:0] IX_RSV_C  = 5'd29;

  localparam int unsigned MCE_BIT   = 6;
  localparam int unsigned WIDE_BIT  = 6;
  localparam int unsigned PEND_BIT  = 4;
  localparam int unsigned BUSY_BIT  = 5;
  localparam int unsigned RSV9_BIT  = 5;

  // Power-on content of each indirect register
  function automatic logic [BYTE_W-1:0] reg_reset_value(input int unsigned n);
    case (n)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  // Effective indirect select from the pointer and the addressing mode
  function automatic logic [SEL_W-1:0] pick_index(input logic [6:0] ptr, input logic wide);
    return wide ? ptr[4:0] : {1'b0, ptr[3:0]};
  endfunction

  // Format byte with either the whole byte or only the upper nibble opened
  function automatic logic [BYTE_W-1:0] fmt_merge(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] new_v,
                                                   input logic whole);
    return whole ? new_v : {new_v[7:4], old_v[3:0]};
  endfunction

endpackage

// File: rtl/codec_regif_index.sv
module codec_regif_index
  import codec_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [6:0]       wdata,
  input  logic             wide,
  input  logic             cal_ok,
  output logic [6:0]       ptr_q,
  output logic [SEL_W-1:0] sel,
  output logic             mce,
  output logic             cal_arm
);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= 7'h40;
    else if (wr_en) ptr_q <= wdata;
  end

  assign mce     = ptr_q[MCE_BIT];
  assign sel     = pick_index(ptr_q, wide);
  assign cal_arm = wr_en && !ptr_q[MCE_BIT] && wdata[MCE_BIT] && cal_ok;

endmodule

// File: rtl/codec_regif_calib.sv
module codec_regif_calib #(
  parameter int unsigned CAL_RELOAD = 1,
  parameter int unsigned CAL_W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic consume,
  output logic busy
);

  logic [CAL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= CAL_W'(CAL_RELOAD);
    else if (consume && busy)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/codec_regif_wpolicy.sv
module codec_regif_wpolicy
  import codec_regif_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] old_v,
  input  logic              mce,
  input  logic              pend,
  output logic              accept,
  output logic [BYTE_W-1:0] store_v,
  output logic              pend_drop
);

  always_comb begin
    accept    = 1'b1;
    store_v   = wdata;
    pend_drop = 1'b0;
    case (sel)
      IX_RSV_A, IX_RSV_B, IX_RSV_C, IX_INIT: accept = 1'b0;
      IX_MODE: begin
        store_v = old_v;
        store_v[WIDE_BIT] = wdata[WIDE_BIT];
      end
      IX_IFCFG: store_v[RSV9_BIT] = 1'b0;
      IX_FMT: begin
        accept  = mce || pend;
        store_v = fmt_merge(old_v, wdata, mce);
      end
      IX_ALTST: pend_drop = old_v[PEND_BIT] && !wdata[PEND_BIT];
      default: ;
    endcase
  end

endmodule

// File: rtl/codec_regif_bank.sv
module codec_regif_bank
  import codec_regif_pkg::*;
#(
  parameter int unsigned NREG = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [BYTE_W-1:0]      wr_val,
  input  logic                   status_clr,
  input  logic                   set_pend,
  output logic [NREG*BYTE_W-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] q, nxt;
    always_comb begin
      nxt = q;
      if (wr_en && wr_sel == SEL_W'(g)) nxt = wr_val;
      if (SEL_W'(g) == IX_ALTST) begin
        if (status_clr) nxt[6:4] = 3'b000;
        if (set_pend)   nxt[PEND_BIT] = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q <= reg_reset_value(g);
      else        q <= nxt;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end

endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int unsigned NREG       = 32,
  parameter int unsigned CAL_RELOAD = 1,
  parameter int unsigned CAL_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   set_irq,
  output logic                   irq,
  output logic                   fmt_load,
  output logic [NREG*BYTE_W-1:0] regs_flat
);

  localparam logic [1:0] P_INDEX  = 2'd0;
  localparam logic [1:0] P_DATA   = 2'd1;
  localparam logic [1:0] P_STATUS = 2'd2;

  logic [BYTE_W-1:0] reg_arr [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs_flat[g*BYTE_W +: BYTE_W];
  end

  logic             idx_wr, data_wr, status_wr, data_rd;
  logic [6:0]       ptr_q;
  logic [SEL_W-1:0] sel;
  logic             mce, cal_arm, cal_busy;
  logic             wide, cal_ok, pend;
  logic             accept, pend_drop;
  logic [7:0]       store_v, cur_v;
  logic             int_q, fmt_q;

  assign idx_wr    = bus_wr && bus_addr == P_INDEX;
  assign data_wr   = bus_wr && bus_addr == P_DATA;
  assign status_wr = bus_wr && bus_addr == P_STATUS;
  assign data_rd   = bus_rd && bus_addr == P_DATA;

  assign wide   = reg_arr[IX_MODE][WIDE_BIT];
  assign cal_ok = reg_arr[IX_IFCFG][4:3] != 2'b00;
  assign pend   = reg_arr[IX_ALTST][PEND_BIT];
  assign cur_v  = reg_arr[sel];

  codec_regif_index u_index (
    .clk(clk), .rst_n(rst_n), .wr_en(idx_wr), .wdata(bus_wdata[6:0]),
    .wide(wide), .cal_ok(cal_ok), .ptr_q(ptr_q), .sel(sel), .mce(mce),
    .cal_arm(cal_arm)
  );

  codec_regif_calib #(.CAL_RELOAD(CAL_RELOAD), .CAL_W(CAL_W)) u_calib (
    .clk(clk), .rst_n(rst_n), .load(cal_arm),
    .consume(data_rd && sel == IX_INIT), .busy(cal_busy)
  );

  codec_regif_wpolicy u_policy (
    .sel(sel), .wdata(bus_wdata), .old_v(cur_v), .mce(mce), .pend(pend),
    .accept(accept), .store_v(store_v), .pend_drop(pend_drop)
  );

  codec_regif_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr && accept), .wr_sel(sel),
    .wr_val(store_v), .status_clr(status_wr), .set_pend(set_irq),
    .regs_flat(regs_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      fmt_q <= 1'b0;
    end else begin
      fmt_q <= data_wr && accept && sel == IX_FMT;
      if (set_irq)                                  int_q <= 1'b1;
      else if (status_wr || (data_wr && pend_drop)) int_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      P_INDEX:  bus_rdata = {1'b0, ptr_q};
      P_DATA: begin
        bus_rdata = cur_v;
        if (sel == IX_INIT && cal_busy) bus_rdata[BUSY_BIT] = 1'b1;
      end
      P_STATUS: bus_rdata = {7'b0, int_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign irq      = int_q;
  assign fmt_load = fmt_q;

endmodule

// File: rtl/codec_regif_checker.sv
module codec_regif_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [7:0]   bus_rdata,
  input logic         set_irq,
  input logic         irq,
  input logic         fmt_load,
  input logic [255:0] regs_flat,
  input logic         cal_busy
);

  a_r1_index_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> !bus_rdata[7]);

  a_r4_init_reg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_flat[95:88]));

  a_r4_mode_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_flat[103:96] & 8'hBF));

  a_r4_ifcfg_bit5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_flat[77]);

  a_r7_fmt_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_load |-> $stable(regs_flat[71:64]));

  a_r8_busy_from_index_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(bus_wr && bus_addr == 2'd0));

  a_r9_status_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !set_irq) |=> !irq);

  a_r11_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq |=> irq && regs_flat[196]);

  a_r12_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd2 |-> bus_rdata == {7'b0, irq});

endmodule

bind codec_regif codec_regif_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .set_irq(set_irq), .irq(irq), .fmt_load(fmt_load),
  .regs_flat(regs_flat), .cal_busy(cal_busy)
);

// File: tb/codec_regif_test.sv
module codec_regif_test;

  localparam int CAL = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0, set_irq = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         irq, fmt_load;
  logic [255:0] regs_flat;

  codec_regif #(.CAL_RELOAD(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_irq(set_irq), .irq(irq), .fmt_load(fmt_load), .regs_flat(regs_flat)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_reg [32];
  logic [6:0] m_idx;
  logic       m_int;
  int         m_cal;

  function automatic logic [7:0] power_on(input int n);
    if (n inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (n == 6 || n == 7) return 8'h80;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    if (n == 25 || n == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic int cur_sel();
    return m_reg[12][6] ? int'(m_idx & 7'h1F) : int'(m_idx & 7'h0F);
  endfunction

  function automatic logic [7:0] predict(input logic [1:0] a);
    logic [7:0] v;
    case (a)
      2'd0: v = {1'b0, m_idx};
      2'd1: begin
        v = m_reg[cur_sel()];
        if (cur_sel() == 11 && m_cal > 0) v = v | 8'h20;
      end
      2'd2: v = {7'b0, m_int};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit set, input string tag);
    int s;
    bit acc;
    logic [7:0] old;
    acc = 0;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; set_irq = set;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; set_irq = 1'b0;
    case (a)
      2'd0: begin
        if (!m_idx[6] && d[6] && m_reg[9][4:3] != 2'b00) m_cal = CAL;
        m_idx = d[6:0];
      end
      2'd1: begin
        s = cur_sel();
        old = m_reg[s];
        if (s == 8) begin
          if (m_idx[6]) begin m_reg[8] = d; acc = 1; end
          else if (m_reg[24][4]) begin m_reg[8] = {d[7:4], old[3:0]}; acc = 1; end
        end else if (s == 12) m_reg[12][6] = d[6];
        else if (s == 9) m_reg[9] = d & 8'hDF;
        else if (s == 24) begin
          if (old[4] && !d[4]) m_int = 1'b0;
          m_reg[24] = d;
        end else if (!(s inside {11, 21, 27, 29})) m_reg[s] = d;
      end
      2'd2: begin
        m_int = 1'b0;
        m_reg[24] = m_reg[24] & 8'h8F;
      end
      default: ;
    endcase
    if (set) begin
      m_int = 1'b1;
      m_reg[24][4] = 1'b1;
    end
    check({tag, " fmt_load"}, {7'b0, fmt_load}, {7'b0, acc});
    check({tag, " irq"}, {7'b0, irq}, {7'b0, m_int});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(tag, bus_rdata, predict(a));
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
    if (a == 2'd1 && cur_sel() == 11 && m_cal > 0) m_cal--;
  endtask

  task automatic rd_reg(input int n, input string tag);
    wr(2'd0, {1'b0, m_idx[6], 1'b0, 5'(n)}, 0, tag);
    rd(2'd1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) m_reg[i] = power_on(i);
    m_idx = 7'h40; m_int = 1'b0; m_cal = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R12 reset state of direct ports
    rd(2'd0, "R1 index reset");
    rd(2'd2, "R12 status reset");
    rd(2'd3, "R1 pio reads zero");
    wr(2'd3, 8'hFF, 0, "R1 pio write");
    rd(2'd3, "R1 pio still zero");
    wr(2'd0, 8'hFF, 0, "R1 index bit7");
    rd(2'd0, "R1 index bit7 reads 0");

    // R3 reset values, narrow then wide
    for (int i = 0; i < 16; i++) rd_reg(i, "R3 narrow reset");
    wr(2'd0, 8'h0C, 0, "R2 point mode");
    wr(2'd1, 8'h40, 0, "R2 enable wide");
    for (int i = 16; i < 32; i++) rd_reg(i, "R3 wide reset");

    // R4 protection
    foreach (m_reg[i]) begin
      if (i inside {21, 27, 29, 11}) begin
        wr(2'd0, 8'(i), 0, "R4 point");
        wr(2'd1, 8'h5A, 0, "R4 protected write");
        rd(2'd1, "R4 protected readback");
      end
    end
    wr(2'd0, 8'h0C, 0, "R4 point mode");
    wr(2'd1, 8'h7F, 0, "R4 mode write");
    rd(2'd1, "R4 mode only bit6");
    wr(2'd0, 8'h09, 0, "R4 point ifcfg");
    wr(2'd1, 8'hFF, 0, "R4 ifcfg write");
    rd(2'd1, "R4 ifcfg bit5 zero");

    // R2 narrow masking: pointer 0x18 reaches reg 8 when narrow
    wr(2'd0, 8'h0C, 0, "R2 point mode");
    wr(2'd1, 8'h00, 0, "R2 disable wide");
    wr(2'd0, 8'h18, 0, "R2 pointer 24");
    rd(2'd1, "R2 narrow alias of 8");

    // R5 / R6 / R7 format gating
    wr(2'd0, 8'h48, 0, "R5 point fmt mce");
    wr(2'd1, 8'h3C, 0, "R5 full write");
    rd(2'd1, "R5 full readback");
    wr(2'd0, 8'h08, 0, "R7 point fmt no mce");
    wr(2'd1, 8'hC3, 0, "R7 dropped write");
    rd(2'd1, "R7 dropped readback");
    wr(2'd0, 8'h0C, 0, "R6 point mode");
    wr(2'd1, 8'h40, 0, "R6 wide");
    wr(2'd0, 8'h18, 0, "R6 point altst");
    wr(2'd1, 8'h10, 0, "R10 set bit4 no int");
    wr(2'd0, 8'h08, 0, "R6 point fmt");
    wr(2'd1, 8'hA5, 0, "R6 partial write");
    rd(2'd1, "R6 upper nibble only");

    // R8 calibration busy
    wr(2'd0, 8'h09, 0, "R8 point ifcfg");
    wr(2'd1, 8'h18, 0, "R8 arm cfg");
    wr(2'd0, 8'h0B, 0, "R8 point init");
    wr(2'd0, 8'h4B, 0, "R8 mce rise");
    for (int k = 0; k < CAL + 1; k++) rd(2'd1, "R8 busy countdown");
    wr(2'd0, 8'h09, 0, "R8 point ifcfg");
    wr(2'd1, 8'h00, 0, "R8 disarm cfg");
    wr(2'd0, 8'h0B, 0, "R8 mce low");
    wr(2'd0, 8'h4B, 0, "R8 rise without arm");
    rd(2'd1, "R8 no busy");

    // R9 / R10 / R11 interrupts, including same-cycle collisions
    wr(2'd3, 8'h00, 1, "R11 set");
    rd(2'd2, "R12 int set");
    wr(2'd0, 8'h18, 0, "R10 point altst");
    rd(2'd1, "R11 pend bit set");
    wr(2'd1, 8'h60, 0, "R10 pend drop clears");
    rd(2'd2, "R10 int cleared");
    wr(2'd1, 8'h10, 1, "R11 set");
    wr(2'd1, 8'h00, 1, "R11 set beats pend drop");
    rd(2'd2, "R11 int kept");
    wr(2'd1, 8'h70, 0, "R9 preload bits");
    wr(2'd2, 8'h00, 0, "R9 status write");
    rd(2'd1, "R9 altst bits cleared");
    wr(2'd1, 8'h70, 0, "R11 preload bits");
    wr(2'd2, 8'h00, 1, "R11 set beats status write");
    rd(2'd1, "R11 altst after collision");
    rd(2'd2, "R11 int after collision");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (op < 30) wr(2'd0, 8'($urandom), ($urandom_range(0, 9) == 0), "RND index");
      else if (op < 55) wr(2'd1, 8'($urandom), ($urandom_range(0, 9) == 0), "RND data");
      else if (op < 60) wr(2'd2, 8'($urandom), ($urandom_range(0, 3) == 0), "RND status");
      else if (op < 62) wr(2'd3, 8'($urandom), 0, "RND pio");
      else rd(2'($urandom_range(0, 3)), "RND read");
    end

    finish_run();
  end

endmodule